// File: doc/BRIEF.md
# Page Write Buffer with Write Protection

This block is the back end of a small serial byte memory. A front end that decodes the bus passes it simple strobes. One strobe loads a word address. Another delivers each data byte. A third marks the end of the transfer, and a fourth sets a permanent software lock. The block gathers the data bytes into a page buffer of `1 << PAGE_BITS` bytes. The upper address bits stay fixed and the lower bits wrap inside the page. When the transfer ends, the block commits the buffered bytes to an external byte array through a write port.

Each commit is followed by a self-timed busy period of exactly `WCYC` clock cycles. This period stands in for the erase and program time of a real cell. While busy is high, the block accepts no strobes. Two kinds of protection filter the commit, byte by byte. A one-time software lock shields the lower half of the address space (MSB of the address = 0). A hardware protect level shields every address. A blocked commit still takes the full busy time, and the front end still acknowledges the bytes.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and the software lock is clear.
- R2: Each data byte goes to the buffer slot given by the low `PAGE_BITS` of the address pointer. That low field then increments by one, and the upper bits never change. Every array write of a commit carries the page's upper bits.
- R3: If more than one page of bytes arrives before the end strobe, the low field wraps, and each slot keeps the last byte sent to it.
- R4: An end strobe with no data byte since the last address load starts no commit, and `busy` stays low.
- R5: An end strobe that has buffered bytes raises `busy` on the next cycle, and `busy` stays high for exactly `WCYC` cycles.
- R6: During the first `1 << PAGE_BITS` busy cycles, the block visits the buffer slots in ascending order, one slot per cycle. It writes every filled, unshielded slot at most once. No write happens outside busy. `WCYC` must be at least the page size.
- R7: Once the lock is set, writes to addresses with MSB = 0 are dropped, and writes to addresses with MSB = 1 still go through.
- R8: The lock cannot be cleared by any strobe; only reset clears it.
- R9: When `wp_level` is high at the end strobe, the block drops every byte of that commit, whatever the lock state. Later changes of `wp_level` during the busy period have no effect.
- R10: A commit whose bytes are all dropped still keeps `busy` high for the full `WCYC` cycles.
- R11: While `busy` is high, the block ignores all four strobes. In particular, the lock is not set and the pointer is not reloaded.
- R12: Data and end strobes do nothing unless an address load came first. An end strobe disarms the block until the next address load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_load | input | 1 | Load `addr_in` as the word pointer and empty the buffer (highest priority strobe) |
| addr_in | input | AW | Word address |
| data_stb | input | 1 | One data byte is present on `data_in` (lowest priority strobe) |
| data_in | input | DW | Data byte |
| stop_stb | input | 1 | End of write transfer (priority between the other two strobes) |
| lock_stb | input | 1 | Set the permanent lower-half lock |
| wp_level | input | 1 | Hardware protect level for the whole array |
| busy | output | 1 | Self-timed write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
The hardest case to reach from the ports is one where the protection state seen at commit time differs from the state while the block is busy. One example is a protect level that drops in the middle of the busy period. Another is a lock strobe or an address load that lands while the block is busy. The stimulus reaches these cases by firing strobes and toggling `wp_level` inside the busy window. It then runs a later commit whose result exposes any state that leaked in. It also sends eighteen bytes into a page that starts two slots below the wrap point, so that both wrapped slots get overwritten.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_DATA,
        ACT_STOP
    } pwb_act_e;

    // Strobe arbitration: address load, then end of transfer, then data.
    function automatic pwb_act_e pick_action(
        input logic open,
        input logic armed,
        input logic load,
        input logic stop,
        input logic data
    );
        pwb_act_e a;
        a = ACT_IDLE;
        if (open) begin
            if (load)
                a = ACT_LOAD;
            else if (stop && armed)
                a = ACT_STOP;
            else if (data && armed)
                a = ACT_DATA;
        end
        return a;
    endfunction

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int DW        = 8,
    parameter int PAGE_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_slot,
    input  logic [DW-1:0]        wr_data,
    input  logic [PAGE_BITS-1:0] rd_slot,
    output logic [DW-1:0]        rd_data,
    output logic                 rd_valid,
    output logic                 any_valid
);
    localparam int PAGE = 1 << PAGE_BITS;

    typedef struct packed {
        logic [PAGE-1:0]         vld;
        logic [PAGE-1:0][DW-1:0] dat;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.vld = '0;
        end else if (wr_en) begin
            st_d.vld[wr_slot] = 1'b1;
            st_d.dat[wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_data   = st_q.dat[rd_slot];
    assign rd_valid  = st_q.vld[rd_slot];
    assign any_valid = |st_q.vld;

    // R2: a stored byte is marked present in the slot it was aimed at
    p_fill_marks_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> st_q.vld[$past(wr_slot)]);

    // R3: a later byte to the same slot replaces the earlier one
    p_last_byte_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (st_q.dat[$past(wr_slot)] == $past(wr_data)));

endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_set,
    input  logic          snap_en,
    input  logic          wp_level,
    input  logic [AW-1:0] chk_addr,
    output logic          lock_on,
    output logic          shielded
);
    typedef struct packed {
        logic lock;
        logic wp_snap;
    } prot_t;

    prot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_set)
            st_d.lock = 1'b1;
        if (snap_en)
            st_d.wp_snap = wp_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lock_on  = st_q.lock;
    assign shielded = st_q.wp_snap | (st_q.lock & ~chk_addr[AW-1]);

    // R8: the lock never returns to clear while out of reset
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);

    // R9: the captured protect level only moves on a commit start
    p_wp_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(st_q.wp_snap));

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
    parameter int PAGE_BITS = 4,
    parameter int WCYC      = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 busy,
    output logic                 scan_active,
    output logic [PAGE_BITS-1:0] scan_slot
);
    localparam int CW   = $clog2(WCYC + 1);
    localparam int PAGE = 1 << PAGE_BITS;

    typedef struct packed {
        logic [CW-1:0]      cnt;
        logic [PAGE_BITS:0] scan;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt  = CW'(WCYC);
            st_d.scan = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (!st_q.scan[PAGE_BITS])
                st_d.scan = st_q.scan + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.scan <= (PAGE_BITS + 1)'(PAGE);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.cnt != '0);
    assign scan_active = busy & ~st_q.scan[PAGE_BITS];
    assign scan_slot   = st_q.scan[PAGE_BITS-1:0];

    // R11: a new commit is never launched over a running one
    p_start_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R5: busy rises exactly one cycle after a start
    p_busy_follows_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int PAGE_BITS = 4,
    parameter int WCYC      = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          data_stb,
    input  logic [DW-1:0] data_in,
    input  logic          stop_stb,
    input  logic          lock_stb,
    input  logic          wp_level,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    import pwb_pkg::*;

    localparam int HI = AW - PAGE_BITS;

    typedef struct packed {
        logic          armed;
        logic [AW-1:0] ptr;
    } front_t;

    front_t   st_d, st_q;
    pwb_act_e act;
    logic     any_valid;
    logic     start;
    logic     scan_active;
    logic [PAGE_BITS-1:0] scan_slot;
    logic [PAGE_BITS-1:0] lo_next;
    logic [DW-1:0]        rd_data;
    logic                 rd_valid;
    logic                 lock_on;
    logic                 shielded;
    logic [AW-1:0]        commit_addr;

    always_comb begin
        act     = pick_action(!busy, st_q.armed, addr_load, stop_stb, data_stb);
        lo_next = st_q.ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);
        start   = (act == ACT_STOP) && any_valid;
        st_d    = st_q;
        case (act)
            ACT_LOAD: begin
                st_d.armed = 1'b1;
                st_d.ptr   = addr_in;
            end
            ACT_STOP: st_d.armed = 1'b0;
            ACT_DATA: st_d.ptr   = {st_q.ptr[AW-1:PAGE_BITS], lo_next};
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    pwb_page_buf #(.DW(DW), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (act == ACT_LOAD),
        .wr_en    (act == ACT_DATA),
        .wr_slot  (st_q.ptr[PAGE_BITS-1:0]),
        .wr_data  (data_in),
        .rd_slot  (scan_slot),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .any_valid(any_valid)
    );

    pwb_commit_seq #(.PAGE_BITS(PAGE_BITS), .WCYC(WCYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .scan_active(scan_active),
        .scan_slot  (scan_slot)
    );

    assign commit_addr = {st_q.ptr[AW-1:PAGE_BITS], scan_slot};

    pwb_protect #(.AW(AW)) u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_set(!busy && lock_stb),
        .snap_en (start),
        .wp_level(wp_level),
        .chk_addr(commit_addr),
        .lock_on (lock_on),
        .shielded(shielded)
    );

    assign mem_we    = scan_active & rd_valid & ~shielded;
    assign mem_addr  = commit_addr;
    assign mem_wdata = rd_data;

    // R6: the array is only written inside a busy period
    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6: back-to-back writes move to a strictly higher slot
    p_slot_rising_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_addr[PAGE_BITS-1:0] > $past(mem_addr[PAGE_BITS-1:0])));

    // R2: all writes of one commit share the page bits
    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_addr[AW-1:PAGE_BITS] == $past(mem_addr[AW-1:PAGE_BITS])));

    // R7: with the lock set only the upper half is ever written
    p_low_half_shielded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && lock_on) |-> mem_addr[AW-1]);

    // R4: an end strobe on an empty buffer leaves busy low
    p_empty_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STOP && !any_valid) |=> !busy);

    // R11: the pointer does not move while busy
    p_ptr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.ptr));

    // R12: a disarmed block ignores data strobes
    p_disarmed_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !addr_load) |=> (!st_q.armed && $stable(st_q.ptr)));

    logic unused_hi;
    assign unused_hi = ^HI;

endmodule

// File: tb/tb_page_commit_unit.sv
module tb_page_commit_unit;
    localparam int AW = 8, DW = 8, PB = 4, WCYC = 40;
    localparam int PAGE = 1 << PB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic addr_load = 0, data_stb = 0, stop_stb = 0, lock_stb = 0, wp_level = 0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    always #2 clk = ~clk;   // 250 MHz

    page_commit_unit #(.AW(AW), .DW(DW), .PAGE_BITS(PB), .WCYC(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .data_stb(data_stb), .data_in(data_in), .stop_stb(stop_stb),
        .lock_stb(lock_stb), .wp_level(wp_level), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    int n_chk = 0, n_bad = 0;
    int img [256];
    int run = 0, last_run = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_cnt = 0, m_scan = PAGE, m_ptr = 0;
    bit  m_armed = 0, m_lock = 0, m_open, m_any;
    int  m_buf [PAGE];
    bit  m_vld [PAGE];
    bit  p_we [PAGE];
    int  p_addr [PAGE], p_data [PAGE];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_scan = PAGE; m_ptr = 0; m_armed = 0; m_lock = 0;
            foreach (m_vld[i]) m_vld[i] = 0;
        end else begin
            m_open = (m_cnt == 0);
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_scan < PAGE) m_scan++;
            end
            if (m_open) begin
                if (lock_stb) m_lock = 1;
                if (addr_load) begin
                    m_armed = 1; m_ptr = int'(addr_in);
                    foreach (m_vld[i]) m_vld[i] = 0;
                end else if (stop_stb && m_armed) begin
                    m_armed = 0; m_any = 0;
                    foreach (m_vld[i]) m_any |= m_vld[i];
                    if (m_any) begin
                        for (int k = 0; k < PAGE; k++) begin
                            p_addr[k] = (m_ptr / PAGE) * PAGE + k;
                            p_data[k] = m_buf[k];
                            p_we[k]   = m_vld[k] && !(wp_level || (m_lock && p_addr[k] < 128));
                        end
                        m_cnt = WCYC; m_scan = 0;
                    end
                end else if (data_stb && m_armed) begin
                    m_buf[m_ptr % PAGE] = int'(data_in);
                    m_vld[m_ptr % PAGE] = 1;
                    m_ptr = (m_ptr / PAGE) * PAGE + ((m_ptr + 1) % PAGE);
                end
            end
        end
    end

    // per-cycle comparison, write capture and busy-length measure
    always @(negedge clk) begin
        bit e_busy, e_we;
        if (rst_n) begin
            e_busy = (m_cnt > 0);
            e_we   = e_busy && m_scan < PAGE && p_we[m_scan];
            chk(busy == e_busy, "R5 busy", int'(busy), int'(e_busy));
            chk(mem_we == e_we, "R6 mem_we", int'(mem_we), int'(e_we));
            if (e_we && mem_we) begin
                chk(int'(mem_addr) == p_addr[m_scan], "R2 mem_addr", int'(mem_addr), p_addr[m_scan]);
                chk(int'(mem_wdata) == p_data[m_scan], "R3 mem_wdata", int'(mem_wdata), p_data[m_scan]);
            end
            if (mem_we) img[mem_addr] = int'(mem_wdata);
            if (busy) run++;
            else if (run > 0) begin last_run = run; run = 0; end
        end
    end

    task automatic tick(); @(negedge clk); #1; endtask
    task automatic p_addr_t(input int a);
        addr_in = AW'(a); addr_load = 1; tick(); addr_load = 0;
    endtask
    task automatic p_data_t(input int d);
        data_in = DW'(d); data_stb = 1; tick(); data_stb = 0;
    endtask
    task automatic p_stop_t(); stop_stb = 1; tick(); stop_stb = 0; endtask
    task automatic p_lock_t(); lock_stb = 1; tick(); lock_stb = 0; endtask
    task automatic wait_idle();
        tick();
        while (busy) tick();
        tick();
    endtask
    task automatic do_reset();
        rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
    endtask
    task automatic one_byte(input int a, input int d);
        p_addr_t(a); p_data_t(d); p_stop_t(); wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (img[i]) img[i] = -1;
        do_reset();
        chk(busy == 0, "R1 busy after reset", int'(busy), 0);
        chk(mem_we == 0, "R1 mem_we after reset", int'(mem_we), 0);

        // R2 / R5: short page write
        p_addr_t('h93); p_data_t('hA1); p_data_t('hA2); p_data_t('hA3); p_stop_t();
        wait_idle();
        chk(img['h93] == 'hA1, "R2 byte0", img['h93], 'hA1);
        chk(img['h95] == 'hA3, "R2 byte2", img['h95], 'hA3);
        chk(last_run == WCYC, "R5 busy length", last_run, WCYC);

        // R3: 18 bytes from slot 0xE wrap over slots E and F
        p_addr_t('hAE);
        for (int i = 0; i < 18; i++) p_data_t('h10 + i);
        p_stop_t(); wait_idle();
        chk(img['hAE] == 'h20, "R3 slot E overwritten", img['hAE], 'h20);
        chk(img['hAF] == 'h21, "R3 slot F overwritten", img['hAF], 'h21);
        chk(img['hA0] == 'h12, "R3 slot 0", img['hA0], 'h12);
        chk(img['hB0] == -1, "R2 no carry into next page", img['hB0], -1);

        // R4: end strobe with empty buffer
        p_addr_t('h40); p_stop_t(); tick(); tick();
        chk(busy == 0, "R4 empty stop keeps idle", int'(busy), 0);

        // R12: data without a preceding address load
        p_data_t('h99); p_stop_t(); tick();
        chk(busy == 0, "R12 disarmed stop", int'(busy), 0);
        chk(img['h40] == -1, "R12 nothing written", img['h40], -1);

        // R11: strobes during busy are ignored
        p_addr_t('h30); p_data_t('h55); p_stop_t();
        p_lock_t(); p_addr_t('h60); p_data_t('h77); p_stop_t();
        wait_idle();
        p_data_t('h78); p_stop_t(); tick();
        chk(busy == 0, "R11 address load in busy ignored", int'(busy), 0);
        one_byte('h31, 'h66);
        chk(img['h31] == 'h66, "R11 lock strobe in busy ignored", img['h31], 'h66);

        // R7 / R10: lock shields the lower half only
        p_lock_t();
        one_byte('h10, 'hC3);
        chk(img['h10] == -1, "R7 low half blocked", img['h10], -1);
        chk(last_run == WCYC, "R10 blocked commit full time", last_run, WCYC);
        one_byte('h90, 'h3C);
        chk(img['h90] == 'h3C, "R7 upper half written", img['h90], 'h3C);

        // R8: lock stays on
        p_lock_t();
        one_byte('h20, 'h11);
        chk(img['h20] == -1, "R8 lock persists", img['h20], -1);

        // R9: protect level at end strobe decides; drop it mid-busy
        p_addr_t('hC0); p_data_t('h5A); wp_level = 1; p_stop_t(); wp_level = 0;
        wait_idle();
        chk(img['hC0] == -1, "R9 wp blocks commit", img['hC0], -1);
        chk(last_run == WCYC, "R10 wp blocked full time", last_run, WCYC);
        one_byte('hC1, 'hE7);
        chk(img['hC1] == 'hE7, "R9 wp released", img['hC1], 'hE7);

        // R8: only reset clears the lock
        do_reset();
        one_byte('h22, 'h44);
        chk(img['h22] == 'h44, "R8 reset clears lock", img['h22], 'h44);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule